// File: doc/BRIEF.md
# Module Description EEPROM Serial Slave

This block is a two-wire serial slave that holds the description data of a memory module. The storage is 256 bytes. The lower half is a fixed identification region: module type, organisation and timing bytes, with one checksum byte. The upper half is free for user data and can be written over the bus. A host reads and writes through an internal byte pointer. It first sets the pointer with a write transfer. It then reads, either after a repeated start or in a later transfer, and the read continues from wherever the pointer was left.

Three strap inputs choose one of eight bus addresses, so up to eight modules can share one bus. Both bus lines first pass through a synchronizer and a stability filter, which removes short noise pulses. When a stop ends a transfer that wrote at least one data byte, the slave models a nonvolatile write cycle. For a parameterised number of clocks it does not respond to its own address.

Top module: `spd_eeprom_slave`

## Requirements
- R1: The slave acknowledges only the 7-bit address `1010` followed by `strap[2:0]`, sent MSB first, with the read/write flag as the eighth bit (1 = read). Any other address gets no acknowledge, and SDA stays released.
- R2: During reset, and after it, the slave leaves SDA released (`sda_oe` = 0).
- R3: In a write transfer, the byte after the device address loads the pointer. Each following data byte is stored at the pointer, the pointer then increments, and every byte is acknowledged. Bytes written to addresses 128..255 read back unchanged.
- R4: Data bytes written to addresses 0..127 are acknowledged, but they leave the stored content unchanged.
- R5: A read transfer returns the byte at the current pointer, MSB first, and increments the pointer after each byte. The pointer survives from one transfer to the next. An acknowledge from the master continues the read; a not-acknowledge ends it.
- R6: A repeated start after a pointer write begins a read at the new pointer.
- R7: During a sequential read the pointer wraps from 255 to 0.
- R8: A stop that ends a transfer with at least one written data byte starts a busy window of `BUSY_CYCLES` clocks. During this window the slave does not acknowledge its own address. A transfer that only sets the pointer starts no busy window.
- R9: In the identification region, byte i (0..127, i ≠ 63) equals (i·29 + `ID_SEED`) mod 256. Byte 63 equals the sum of bytes 0..62, mod 256.
- R10: A pulse shorter than `FILT_CYCLES` clocks on SCL or on SDA has no effect on the transfer.
- R11: The slave changes `sda_oe` only while SCL is low, so it never creates a start or a stop condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the bus is oversampled with it |
| rst | input | 1 | Synchronous active-high reset |
| strap | input | 3 | Address select straps, low bits of the slave address |
| scl_in | input | 1 | Sampled serial clock line |
| sda_in | input | 1 | Sampled serial data line |
| sda_oe | output | 1 | 1 pulls the open-drain SDA line low |

## Verification
On every cycle, the checker confirms four things: SDA moves only while the filtered clock is low; an address acknowledge follows only the own address and never a busy state; each stored byte advances the pointer by one; and SDA is released when reset ends. Only the bench scenarios can show the rest. These are the identification content and its checksum, read-back of user bytes, ignored writes to the fixed region, pointer wrap and persistence, the busy window and its end, and rejection of injected noise pulses.

// File: rtl/spd_pkg.sv
package spd_pkg;
  localparam int SPD_AW   = 8;
  localparam int STRAP_W  = 3;
  localparam int CSUM_IDX = 63;
  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [3:0] {
    ST_IDLE, ST_DEV, ST_DEV_ACK, ST_WA, ST_WA_ACK,
    ST_WD, ST_WD_ACK, ST_RD, ST_RD_ACK
  } spd_state_e;

  // Identification byte for a non-checksum location
  function automatic logic [7:0] id_pattern(input logic [SPD_AW-2:0] idx,
                                            input logic [7:0] seed);
    logic [7:0] p;
    p = 8'({1'b0, idx} * 8'd29);
    return p + seed;
  endfunction

  // Sum of all identification bytes below the checksum location
  function automatic logic [7:0] id_checksum(input logic [7:0] seed);
    logic [7:0] s;
    s = 8'd0;
    for (int j = 0; j < CSUM_IDX; j++) s = s + id_pattern((SPD_AW-1)'(j), seed);
    return s;
  endfunction
endpackage

// File: rtl/spd_glitch_filter.sv
module spd_glitch_filter #(
  parameter int FILT_CYCLES = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(FILT_CYCLES + 1);

  logic [1:0]    sync;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync <= 2'b11;
      cnt  <= '0;
      dout <= 1'b1;
    end else begin
      sync <= {sync[0], din};
      if (sync[1] == dout) begin
        cnt <= '0;
      end else if (cnt == CW'(FILT_CYCLES - 1)) begin
        cnt  <= '0;
        dout <= sync[1];
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spd_busy_timer.sv
module spd_busy_timer #(
  parameter int BUSY_CYCLES = 1000000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                cnt <= '0;
    else if (start)         cnt <= CW'(BUSY_CYCLES);
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/spd_store.sv
module spd_store
  import spd_pkg::*;
#(
  parameter logic [7:0] SEED = 8'h5A
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [SPD_AW-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [SPD_AW-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  localparam int LW         = SPD_AW - 1;
  localparam int USER_DEPTH = 2 ** LW;
  localparam logic [7:0] CSUM = id_checksum(SEED);

  logic [7:0] user_mem [USER_DEPTH];
  logic [7:0] id_byte;

  // Upper half is writable RAM; writes to the lower half are dropped
  always_ff @(posedge clk) begin
    if (wr_en && wr_addr[SPD_AW-1]) user_mem[wr_addr[LW-1:0]] <= wr_data;
  end

  always_comb begin
    if (rd_addr[LW-1:0] == LW'(CSUM_IDX)) id_byte = CSUM;
    else                                  id_byte = id_pattern(rd_addr[LW-1:0], SEED);
  end

  always_ff @(posedge clk) begin
    rd_data <= rd_addr[SPD_AW-1] ? user_mem[rd_addr[LW-1:0]] : id_byte;
  end
endmodule

// File: rtl/spd_link_fsm.sv
module spd_link_fsm
  import spd_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               scl,
  input  logic               sda,
  input  logic [STRAP_W-1:0] strap,
  input  logic               busy,
  input  logic [7:0]         rd_data,
  output logic [SPD_AW-1:0]  ptr,
  output logic               wr_en,
  output logic [SPD_AW-1:0]  wr_addr,
  output logic [7:0]         wr_data,
  output logic               write_done,
  output logic               sda_oe,
  output logic               dev_ack,
  output logic [7:0]         rx_byte
);
  spd_state_e state;
  logic       scl_q, sda_q;
  logic [3:0] bitcnt;
  logic [7:0] shreg, txreg;
  logic       rw, mack, wrote;
  logic       scl_rise, scl_fall, start_c, stop_c;

  assign scl_rise = scl & ~scl_q;
  assign scl_fall = ~scl & scl_q;
  assign start_c  = scl & scl_q & sda_q & ~sda;
  assign stop_c   = scl & scl_q & ~sda_q & sda;

  assign dev_ack = (state == ST_DEV_ACK);
  assign rx_byte = shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      scl_q      <= 1'b1;
      sda_q      <= 1'b1;
      bitcnt     <= '0;
      shreg      <= '0;
      txreg      <= '0;
      ptr        <= '0;
      rw         <= 1'b0;
      mack       <= 1'b0;
      wrote      <= 1'b0;
      sda_oe     <= 1'b0;
      wr_en      <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
      write_done <= 1'b0;
    end else begin
      scl_q      <= scl;
      sda_q      <= sda;
      wr_en      <= 1'b0;
      write_done <= 1'b0;
      if (stop_c) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
        if (wrote) write_done <= 1'b1;
        wrote  <= 1'b0;
      end else if (start_c) begin
        state  <= ST_DEV;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_DEV, ST_WA, ST_WD: begin
            if (scl_rise) begin
              shreg  <= {shreg[6:0], sda};
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              if (state == ST_DEV) begin
                if (shreg[7:1] == {DEV_TYPE, strap} && !busy) begin
                  sda_oe <= 1'b1;
                  rw     <= shreg[0];
                  state  <= ST_DEV_ACK;
                end else begin
                  state  <= ST_IDLE;
                end
              end else if (state == ST_WA) begin
                ptr    <= shreg;
                sda_oe <= 1'b1;
                state  <= ST_WA_ACK;
              end else begin
                wr_en   <= 1'b1;
                wr_addr <= ptr;
                wr_data <= shreg;
                ptr     <= ptr + 1'b1;
                wrote   <= 1'b1;
                sda_oe  <= 1'b1;
                state   <= ST_WD_ACK;
              end
            end
          end
          ST_DEV_ACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (rw) begin
                txreg  <= rd_data;
                sda_oe <= ~rd_data[7];
                state  <= ST_RD;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_WA;
              end
            end
          end
          ST_WA_ACK, ST_WD_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              bitcnt <= '0;
              state  <= ST_WD;
            end
          end
          ST_RD: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall) begin
              if (bitcnt == 4'd8) begin
                sda_oe <= 1'b0;
                ptr    <= ptr + 1'b1;
                state  <= ST_RD_ACK;
              end else begin
                txreg  <= {txreg[6:0], 1'b0};
                sda_oe <= ~txreg[6];
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) begin
              mack <= ~sda;
            end else if (scl_fall) begin
              if (mack) begin
                bitcnt <= '0;
                txreg  <= rd_data;
                sda_oe <= ~rd_data[7];
                state  <= ST_RD;
              end else begin
                state  <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/spd_eeprom_slave.sv
module spd_eeprom_slave
  import spd_pkg::*;
#(
  parameter int         FILT_CYCLES = 5,
  parameter int         BUSY_CYCLES = 1000000,
  parameter logic [7:0] ID_SEED     = 8'h5A
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [STRAP_W-1:0] strap,
  input  logic               scl_in,
  input  logic               sda_in,
  output logic               sda_oe
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] line_raw, line_filt;
  logic              scl_f, sda_f, busy, dev_ack, wr_en, write_done;
  logic [SPD_AW-1:0] ptr, wr_addr;
  logic [7:0]        wr_data, rd_data, rx_byte;

  assign line_raw = {sda_in, scl_in};

  for (genvar g = 0; g < NLINES; g++) begin : g_filt
    spd_glitch_filter #(.FILT_CYCLES(FILT_CYCLES)) u_filt (
      .clk  (clk),
      .rst  (rst),
      .din  (line_raw[g]),
      .dout (line_filt[g])
    );
  end

  assign scl_f = line_filt[0];
  assign sda_f = line_filt[1];

  spd_link_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .scl        (scl_f),
    .sda        (sda_f),
    .strap      (strap),
    .busy       (busy),
    .rd_data    (rd_data),
    .ptr        (ptr),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .write_done (write_done),
    .sda_oe     (sda_oe),
    .dev_ack    (dev_ack),
    .rx_byte    (rx_byte)
  );

  spd_store #(.SEED(ID_SEED)) u_store (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (ptr),
    .rd_data (rd_data)
  );

  spd_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
    .clk   (clk),
    .rst   (rst),
    .start (write_done),
    .busy  (busy)
  );
endmodule

// File: rtl/spd_eeprom_checker.sv
module spd_eeprom_checker (
  input logic       clk,
  input logic       rst,
  input logic       sda_oe,
  input logic       scl_f,
  input logic       busy,
  input logic       dev_ack,
  input logic [7:0] rx_byte,
  input logic [2:0] strap,
  input logic       wr_en,
  input logic [7:0] wr_addr,
  input logic [7:0] ptr
);
  a_r2_released_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !sda_oe);

  a_r11_sda_moves_scl_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_f);

  a_r1_ack_own_addr: assert property (@(posedge clk) disable iff (rst)
    $rose(dev_ack) |-> $past(rx_byte[7:1]) == {4'b1010, strap});

  a_r8_no_ack_busy: assert property (@(posedge clk) disable iff (rst)
    $rose(dev_ack) |-> !$past(busy));

  a_r3_ptr_step: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ptr == 8'(wr_addr + 8'd1));
endmodule

bind spd_eeprom_slave spd_eeprom_checker u_chk (
  .clk     (clk),
  .rst     (rst),
  .sda_oe  (sda_oe),
  .scl_f   (scl_f),
  .busy    (busy),
  .dev_ack (dev_ack),
  .rx_byte (rx_byte),
  .strap   (strap),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .ptr     (ptr)
);

// File: tb/test_spd_eeprom_slave.sv
module test_spd_eeprom_slave;
  localparam int CLK_PERIOD = 10;
  localparam int H = 32;
  localparam int Q = 8;
  localparam int BUSY = 2000;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] SEED = 8'h5A;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1, m_sda_oe = 1'b0, scl_glitch = 1'b0, sda_glitch = 1'b0;
  logic sda_oe;
  logic sda_line, scl_in, sda_in;

  assign sda_line = ~(m_sda_oe | sda_oe);
  assign scl_in   = m_scl | scl_glitch;
  assign sda_in   = sda_line & ~sda_glitch;

  always #(CLK_PERIOD/2) clk = ~clk;

  spd_eeprom_slave #(.FILT_CYCLES(5), .BUSY_CYCLES(BUSY), .ID_SEED(SEED)) i_spd_eeprom_slave (
    .clk(clk), .rst(rst), .strap(STRAP), .scl_in(scl_in), .sda_in(sda_in), .sda_oe(sda_oe)
  );

  int n_checks = 0;
  int n_fail = 0;
  int r11_bad = 0;
  logic prev_oe = 1'b0;

  typedef struct { logic [7:0] val; string tag; } exp_t;
  exp_t exp_q[$];
  logic [7:0] obs_val;
  event obs_ev;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  // Scoreboard monitor
  initial begin
    forever begin
      @(obs_ev);
      if (exp_q.size() == 0) begin
        check("scoreboard unexpected item", {24'd0, obs_val}, 32'hFFFF);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.tag, {24'd0, obs_val}, {24'd0, e.val});
      end
    end
  end

  // R11: slave output moves only while master holds SCL low
  always @(posedge clk) begin
    if (!rst && sda_oe != prev_oe && m_scl) r11_bad++;
    prev_oe <= sda_oe;
  end

  initial begin
    repeat (190000) @(posedge clk);
    check("watchdog", 32'd1, 32'd0);
    summary();
  end

  function automatic logic [7:0] exp_id(int i);
    int s;
    s = 0;
    if (i == 63) begin
      for (int j = 0; j < 63; j++) s += j * 29 + int'(SEED);
      return 8'(s);
    end
    return 8'(i * 29 + int'(SEED));
  endfunction

  function automatic logic [7:0] dev(logic rw);
    return {4'b1010, STRAP, rw};
  endfunction

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda_oe = 1'b0; m_scl = 1'b1; wait_clk(H);
    m_sda_oe = 1'b1; wait_clk(H);
    m_scl = 1'b0;
  endtask

  task automatic bus_rstart();
    wait_clk(Q); m_sda_oe = 1'b0; wait_clk(3*Q);
    m_scl = 1'b1; wait_clk(H);
    m_sda_oe = 1'b1; wait_clk(H);
    m_scl = 1'b0;
  endtask

  task automatic bus_stop();
    wait_clk(Q); m_sda_oe = 1'b1; wait_clk(3*Q);
    m_scl = 1'b1; wait_clk(H);
    m_sda_oe = 1'b0; wait_clk(H);
  endtask

  task automatic put_bit(logic b, bit gl);
    wait_clk(Q); m_sda_oe = ~b;
    if (gl) begin
      wait_clk(Q); scl_glitch = 1'b1; wait_clk(3); scl_glitch = 1'b0; wait_clk(2*Q-3);
    end else wait_clk(3*Q);
    m_scl = 1'b1;
    if (gl && b) begin
      wait_clk(Q); sda_glitch = 1'b1; wait_clk(3); sda_glitch = 1'b0; wait_clk(H-Q-3);
    end else wait_clk(H);
    m_scl = 1'b0;
  endtask

  task automatic get_bit(output logic b);
    wait_clk(Q); m_sda_oe = 1'b0; wait_clk(3*Q);
    m_scl = 1'b1; wait_clk(H/2);
    b = sda_line; wait_clk(H/2);
    m_scl = 1'b0;
  endtask

  // Driver: send a byte and push the expected acknowledge (1 = acked)
  task automatic send_byte(logic [7:0] v, bit gl, logic exp_ack, string tag);
    logic a;
    exp_q.push_back('{{7'd0, exp_ack}, tag});
    for (int i = 7; i >= 0; i--) put_bit(v[i], gl);
    get_bit(a);
    obs_val = {7'd0, ~a};
    ->obs_ev;
  endtask

  // Driver: read a byte, push its expected value, then ack or nack
  task automatic recv_byte(logic [7:0] exp, bit ack_it, string tag);
    logic [7:0] v;
    logic b;
    exp_q.push_back('{exp, tag});
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    obs_val = v;
    ->obs_ev;
    put_bit(~ack_it, 1'b0);
  endtask

  initial begin
    wait_clk(5);
    check("R2 sda_oe in reset", {31'd0, sda_oe}, 32'd0);
    rst = 1'b0;
    wait_clk(20);
    check("R2 sda_oe after reset", {31'd0, sda_oe}, 32'd0);

    // R1: foreign addresses are not acknowledged
    bus_start(); send_byte({4'b1010, 3'b010, 1'b0}, 0, 1'b0, "R1 wrong strap"); bus_stop();
    bus_start(); send_byte({4'b1110, STRAP, 1'b0}, 0, 1'b0, "R1 wrong type"); bus_stop();

    // R6/R9: pointer write, repeated start, full identification read
    bus_start();
    send_byte(dev(0), 0, 1'b1, "R6 addr");
    send_byte(8'h00, 0, 1'b1, "R6 pointer");
    bus_rstart();
    send_byte(dev(1), 0, 1'b1, "R6 read addr");
    for (int i = 0; i < 128; i++)
      recv_byte(exp_id(i), i != 127, (i == 63) ? "R9 checksum" : "R9 id byte");
    bus_stop();

    // R8: no busy after a read-only transfer; R3 writes to the user region
    bus_start();
    send_byte(dev(0), 0, 1'b1, "R8 ack after read-only transfer");
    send_byte(8'hFC, 0, 1'b1, "R3 pointer");
    send_byte(8'h11, 0, 1'b1, "R3 data ack");
    send_byte(8'h22, 0, 1'b1, "R3 data ack");
    send_byte(8'h33, 0, 1'b1, "R3 data ack");
    send_byte(8'h44, 0, 1'b1, "R3 data ack");
    bus_stop();
    bus_start(); send_byte(dev(0), 0, 1'b0, "R8 nack while busy"); bus_stop();
    wait_clk(BUSY + 100);

    // R3/R7: read back across the wrap
    bus_start();
    send_byte(dev(0), 0, 1'b1, "R8 ack after busy");
    send_byte(8'hFE, 0, 1'b1, "R7 pointer");
    bus_rstart();
    send_byte(dev(1), 0, 1'b1, "R7 read addr");
    recv_byte(8'h33, 1, "R3 readback FE");
    recv_byte(8'h44, 1, "R3 readback FF");
    recv_byte(exp_id(0), 1, "R7 wrap to 00");
    recv_byte(exp_id(1), 0, "R7 wrap 01");
    bus_stop();

    // R5: current-address read continues at pointer 02
    bus_start();
    send_byte(dev(1), 0, 1'b1, "R5 read addr");
    recv_byte(exp_id(2), 1, "R5 current byte");
    recv_byte(exp_id(3), 0, "R5 next byte");
    bus_stop();

    // R4: write into the identification region is ignored
    bus_start();
    send_byte(dev(0), 0, 1'b1, "R4 addr");
    send_byte(8'h10, 0, 1'b1, "R4 pointer");
    send_byte(8'hA5, 0, 1'b1, "R4 data ack");
    bus_stop();
    wait_clk(BUSY + 100);
    bus_start();
    send_byte(dev(0), 0, 1'b1, "R4 addr");
    send_byte(8'h10, 0, 1'b1, "R4 pointer");
    bus_rstart();
    send_byte(dev(1), 0, 1'b1, "R4 read addr");
    recv_byte(exp_id(16), 0, "R4 id byte unchanged");
    bus_stop();

    // R10: write with noise pulses on both lines
    bus_start();
    send_byte(dev(0), 1, 1'b1, "R10 addr with glitches");
    send_byte(8'h90, 1, 1'b1, "R10 pointer with glitches");
    send_byte(8'hB7, 1, 1'b1, "R10 data with glitches");
    bus_stop();
    wait_clk(BUSY + 100);
    bus_start();
    send_byte(dev(0), 0, 1'b1, "R10 addr");
    send_byte(8'h90, 0, 1'b1, "R10 pointer");
    bus_rstart();
    send_byte(dev(1), 0, 1'b1, "R10 read addr");
    recv_byte(8'hB7, 0, "R10 readback");
    bus_stop();

    wait_clk(10);
    check("scoreboard drained", exp_q.size(), 32'd0);
    check("R11 sda_oe changes with SCL high", r11_bad, 32'd0);
    summary();
  end
endmodule